// File: doc/BRIEF.md
# Match Timer with Watchdog Reset Channel

A free-running 32-bit up-counter shared by a set of compare channels, each holding a match value. When the counter equals a channel's match value, that channel raises a sticky status flag. A per-channel enable turns the flag into an interrupt request. Software can read the live count directly. It can also take a coherent snapshot by writing a capture command and then reading the snapshot register.

One fixed compare channel also serves as the system watchdog. No separate down-counter exists. Software arms the watchdog by setting both that channel's interrupt enable and a global watchdog enable. It keeps the system alive by rewriting the channel's match value as snapshot plus timeout. If the counter reaches the match value while both enables are set, the block emits a one-cycle reset request and disarms itself. The counter advances only on cycles where the tick-enable input is high. A prescaler, if one is needed, sits outside the block.

Top module: `tmr_wdog_top`

## Requirements
- R1: The counter loads `CNT_RESET` on reset. It increments by one (modulo 2^32, so 0xFFFFFFFF wraps to 0) at each clock edge where `tick_i` is high, and holds otherwise. It is read at byte offset 0x00.
- R2: Match register of channel i sits at offset 0x08 + 4*i. It is read/write, resets to 0xFFFFFFFF, and the watchdog channel 5 is at 0x1C.
- R3: Status bit i (offset 0x2C) is set at the clock edge that ends a cycle in which the counter equals match i. It stays set until a bus write to 0x2C with bit i = 1 clears it. A new match in the same cycle as the clear wins.
- R4: `irq_o` is high exactly when some status bit and its enable bit in the interrupt enable register (offset 0x24, bit i for channel i) are both 1.
- R5: A write to 0x30 with bit 0 = 1 copies the counter value of that cycle into the snapshot register at 0x34. A write with bit 0 = 0 leaves the snapshot unchanged. 0x30 reads as 0.
- R6: `rst_req_o` is a one-cycle pulse. It is asserted at the edge ending a cycle in which the counter equals match 5, enable bit 5 is 1 and the watchdog enable (offset 0x28, bit 0) is 1.
- R7: No reset request is produced while enable bit 5 is 0 or the watchdog enable is 0, even when the counter reaches match 5.
- R8: The watchdog enable clears itself at the same edge that raises `rst_req_o`, so 0x28 then reads 0.
- R9: Rewriting match 5 with snapshot + T postpones the reset. With `tick_i` held high, the reset pulse appears (match5 - counter) mod 2^32 falling edges after a counter read returns `counter`, including when the match value wraps past zero.
- R10: Reads of unmapped offsets return 0. Writes to unmapped offsets, to 0x00 and to 0x34 change nothing.
- R11: Read data is registered. `rdata_o` takes the addressed value at the edge that ends the request cycle and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter advance enable |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined channel interrupt |
| rst_req_o | output | 1 | One-cycle watchdog reset request |

## Verification
Read data is due one clock edge after the request cycle. A counter read returns the value the counter held during that cycle, not the value after the edge. Status, interrupt and reset request respond one edge after the cycle in which the counter equals a match value. The bench drives all inputs on falling edges and compares outputs at the following falling edge. It compares them against a reference state that is advanced at rising edges from the same inputs. The watchdog expiry is measured by counting falling edges from a counter read until the pulse, and that count must equal match minus the value read, with wrap-around.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_COUNT    = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_MATCH0   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_IRQ_EN   = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_WD_EN    = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_STATUS   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_SNAP_CTL = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_SNAP     = 8'h34;

  function automatic logic [ADDR_W-1:0] match_off(input int unsigned ch);
    return OFF_MATCH0 + ADDR_W'(ch * 4);
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W         = 32,
  parameter logic [W-1:0] RST_VAL  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= RST_VAL;
    else if (tick_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_match_bank.sv
module tmr_match_bank #(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned W      = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [W-1:0]                 cnt_i,
  input  logic [NUM_CH-1:0]            wr_i,
  input  logic [W-1:0]                 wdata_i,
  input  logic [NUM_CH-1:0]            clr_i,
  output logic [NUM_CH-1:0][W-1:0]     match_o,
  output logic [NUM_CH-1:0]            hit_o,
  output logic [NUM_CH-1:0]            stat_o
);
  logic [W-1:0] match_r [NUM_CH];
  logic         stat_r  [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      match_r[i] <= '1;
      else if (wr_i[i]) match_r[i] <= wdata_i;
    end

    // new hit beats a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_r[i] <= 1'b0;
      else         stat_r[i] <= hit_o[i] | (stat_r[i] & ~clr_i[i]);
    end

    assign hit_o[i]   = (cnt_i == match_r[i]);
    assign match_o[i] = match_r[i];
    assign stat_o[i]  = stat_r[i];
  end
endmodule

// File: rtl/tmr_wdog_gate.sv
module tmr_wdog_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic hit_i,
  input  logic chan_en_i,
  output logic wden_o,
  output logic rst_req_o
);
  logic wden_q, req_q, fire;

  assign fire = hit_i & chan_en_i & wden_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wden_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q <= fire;
      if (fire)      wden_q <= 1'b0;   // disarm after firing
      else if (wr_i) wden_q <= wbit_i;
    end
  end

  assign wden_o    = wden_q;
  assign rst_req_o = req_q;
endmodule

// File: rtl/tmr_wdog_top.sv
module tmr_wdog_top #(
  parameter int unsigned NUM_CH    = 6,
  parameter int unsigned WDOG_CH   = 5,
  parameter logic [31:0] CNT_RESET = 32'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  output logic        rst_req_o
);
  import tmr_pkg::*;

  logic [DATA_W-1:0]              cnt_q;
  logic [NUM_CH-1:0][DATA_W-1:0]  match_q;
  logic [DATA_W-1:0]              match_wd;
  logic [NUM_CH-1:0]              hit, stat_q, ie_q, match_wr, stat_clr;
  logic [DATA_W-1:0]              snap_q, rd_val, rdata_q;
  logic                           wden_q, wr_en, rd_en;

  assign wr_en = req_i & we_i;
  assign rd_en = req_i & ~we_i;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) match_wr[i] = wr_en && (addr_i == match_off(i));
    stat_clr = (wr_en && addr_i == OFF_STATUS) ? wdata_i[NUM_CH-1:0] : '0;
  end

  tmr_counter #(.W(DATA_W), .RST_VAL(CNT_RESET)) i_counter (
    .clk_i, .rst_ni, .tick_i, .cnt_o(cnt_q)
  );

  tmr_match_bank #(.NUM_CH(NUM_CH), .W(DATA_W)) i_bank (
    .clk_i, .rst_ni,
    .cnt_i   (cnt_q),
    .wr_i    (match_wr),
    .wdata_i (wdata_i),
    .clr_i   (stat_clr),
    .match_o (match_q),
    .hit_o   (hit),
    .stat_o  (stat_q)
  );

  assign match_wd = match_q[WDOG_CH];

  tmr_wdog_gate i_gate (
    .clk_i, .rst_ni,
    .wr_i      (wr_en && addr_i == OFF_WD_EN),
    .wbit_i    (wdata_i[0]),
    .hit_i     (hit[WDOG_CH]),
    .chan_en_i (ie_q[WDOG_CH]),
    .wden_o    (wden_q),
    .rst_req_o (rst_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q    <= '0;
      snap_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_en && addr_i == OFF_IRQ_EN)               ie_q   <= wdata_i[NUM_CH-1:0];
      if (wr_en && addr_i == OFF_SNAP_CTL && wdata_i[0]) snap_q <= cnt_q;
      if (rd_en)                                       rdata_q <= rd_val;
    end
  end

  always_comb begin
    rd_val = '0;
    if (addr_i == OFF_COUNT) rd_val = cnt_q;
    for (int i = 0; i < NUM_CH; i++)
      if (addr_i == match_off(i)) rd_val = match_q[i];
    if (addr_i == OFF_IRQ_EN) rd_val[NUM_CH-1:0] = ie_q;
    if (addr_i == OFF_WD_EN)  rd_val[0]          = wden_q;
    if (addr_i == OFF_STATUS) rd_val[NUM_CH-1:0] = stat_q;
    if (addr_i == OFF_SNAP)   rd_val             = snap_q;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |(stat_q & ie_q);
endmodule

// File: rtl/tmr_wdog_chk.sv
module tmr_wdog_chk #(
  parameter int unsigned NUM_CH  = 6,
  parameter int unsigned WDOG_CH = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              rst_req_o,
  input logic [31:0]       cnt_q,
  input logic [31:0]       match_wd,
  input logic [NUM_CH-1:0] ie_q,
  input logic              wden_q,
  input logic [NUM_CH-1:0] stat_q
);
  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> (cnt_q == ($past(tick_i) ? $past(cnt_q) + 32'd1 : $past(cnt_q)))); // R1
  AST_STAT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && $past(cnt_q == match_wd) |-> stat_q[WDOG_CH]); // R3
  AST_RST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R6
  AST_RST_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q && rst_req_o |-> $past(ie_q[WDOG_CH] && wden_q && cnt_q == match_wd)); // R7
  AST_WDEN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> !wden_q); // R8
endmodule

bind tmr_wdog_top tmr_wdog_chk #(.NUM_CH(NUM_CH), .WDOG_CH(WDOG_CH)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .rst_req_o (rst_req_o),
  .cnt_q     (cnt_q),
  .match_wd  (match_wd),
  .ie_q      (ie_q),
  .wden_q    (wden_q),
  .stat_q    (stat_q)
);

// File: tb/test_tmr_wdog_top.sv
module test_tmr_wdog_top;
  localparam int unsigned NCH = 6;
  localparam int unsigned WD  = 5;
  localparam logic [31:0] RST_CNT = 32'hFFFF_FF00;
  localparam logic [31:0] TMO = 32'h180;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, rreq;
  int n_chk = 0, n_err = 0;
  bit running = 1'b0, done = 1'b0;

  always #4 clk = ~clk;

  tmr_wdog_top #(.NUM_CH(NCH), .WDOG_CH(WD), .CNT_RESET(RST_CNT)) i_tmr_wdog_top (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .rst_req_o(rreq)
  );

  // reference state from the requirements
  logic [31:0] m_cnt, m_snap;
  logic [31:0] m_match [NCH];
  logic [NCH-1:0] m_ie, m_stat;
  logic m_wden, m_rst;

  always @(posedge clk or negedge rst_n) begin : mdl
    logic wr, fire;
    logic [NCH-1:0] nstat;
    if (!rst_n) begin
      m_cnt <= RST_CNT; m_snap <= '0; m_ie <= '0; m_stat <= '0;
      m_wden <= 1'b0; m_rst <= 1'b0;
      for (int i = 0; i < NCH; i++) m_match[i] <= '1;
    end else begin
      wr = req && we;
      for (int i = 0; i < NCH; i++) begin
        nstat[i] = (m_cnt == m_match[i]) | (m_stat[i] & ~(wr && addr == 8'h2C && wdata[i]));
        if (wr && addr == 8'(8 + 4 * i)) m_match[i] <= wdata;
      end
      fire = (m_cnt == m_match[WD]) && m_ie[WD] && m_wden;
      m_rst <= fire;
      if (fire) m_wden <= 1'b0;
      else if (wr && addr == 8'h28) m_wden <= wdata[0];
      if (wr && addr == 8'h24) m_ie <= wdata[NCH-1:0];
      if (wr && addr == 8'h30 && wdata[0]) m_snap <= m_cnt;
      if (tick) m_cnt <= m_cnt + 32'd1;
      m_stat <= nstat;
    end
  end

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == 8'h00) return m_cnt;
    for (int i = 0; i < NCH; i++) if (a == 8'(8 + 4 * i)) return m_match[i];
    if (a == 8'h24) return 32'(m_ie);
    if (a == 8'h28) return 32'(m_wden);
    if (a == 8'h2C) return 32'(m_stat);
    if (a == 8'h34) return m_snap;
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a == 8'h00) return "R1";
    if (a >= 8'h08 && a <= 8'h1C && a[1:0] == 2'b00) return "R2";
    if (a == 8'h24) return "R4";
    if (a == 8'h28) return "R8";
    if (a == 8'h2C) return "R3";
    if (a == 8'h34) return "R5";
    return "R10";
  endfunction

  function automatic logic [7:0] pick_addr(input int unsigned k);
    case (k)
      0: return 8'h00;  1: return 8'h04;  8: return 8'h20;  9: return 8'h24;
      10: return 8'h28; 11: return 8'h2C; 12: return 8'h30; 13: return 8'h34;
      14: return 8'h3C;
      default: return 8'(8 + 4 * (k - 2));
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] v);
    logic [31:0] e;
    e = exp_read(a);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    v = rdata;
    chk({tag_of(a), "/R11"}, rdata, e);
  endtask

  always @(negedge clk) begin
    if (running && rst_n) begin
      chk("R4", 32'(irq), 32'(|(m_stat & m_ie)));
      chk("R6", 32'(rreq), 32'(m_rst));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c, m, rem;
    int unsigned n, pulses;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    // reset state
    chk("R6", 32'(rreq), 32'h0);
    chk("R4", 32'(irq), 32'h0);
    bus_rd(8'h00, v); chk("R1", v, RST_CNT);
    bus_rd(8'h1C, v); chk("R2", v, 32'hFFFF_FFFF);
    bus_rd(8'h2C, v); chk("R3", v, 32'h0);

    // arm watchdog, refresh across counter wrap
    tick = 1'b1;
    bus_wr(8'h24, 32'h1 << WD);
    bus_wr(8'h28, 32'h1);
    bus_wr(8'h30, 32'h1);
    bus_rd(8'h34, c);
    bus_wr(8'h1C, c + TMO);
    bus_rd(8'h00, v);
    chk("R1", v, c + 32'd3);
    chk("R9", (c + TMO) - v, TMO - 32'd3);
    repeat (200) @(negedge clk);
    chk("R9", 32'(rreq), 32'h0);
    // refresh: expiry postponed
    bus_wr(8'h30, 32'h1);
    bus_rd(8'h34, c);
    m = c + TMO;
    bus_wr(8'h1C, m);
    bus_rd(8'h00, v);
    rem = m - v;
    n = 0;
    while (!rreq && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk("R9", 32'(n), rem);
    chk("R6", 32'(rreq), 32'h1);
    @(negedge clk);
    chk("R6", 32'(rreq), 32'h0);
    bus_rd(8'h28, v); chk("R8", v, 32'h0);
    bus_rd(8'h2C, v); chk("R3", v & (32'h1 << WD), 32'h1 << WD);
    chk("R4", 32'(irq), 32'h1);
    bus_wr(8'h2C, 32'h1 << WD);
    chk("R3", 32'(irq), 32'h0);

    // gating: channel enable off, then watchdog enable off
    for (int g = 0; g < 2; g++) begin
      bus_wr(8'h24, g == 0 ? 32'h0 : 32'h1 << WD);
      bus_wr(8'h28, g == 0 ? 32'h1 : 32'h0);
      bus_rd(8'h00, v);
      bus_wr(8'h1C, v + 32'd20);
      pulses = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (rreq) pulses++;
      end
      chk("R7", 32'(pulses), 32'h0);
    end

    // snapshot with bit0 clear, writes to read-only / unmapped offsets
    bus_wr(8'h30, 32'h1);
    bus_rd(8'h34, c);
    bus_wr(8'h30, 32'hFFFF_FFFE);
    bus_wr(8'h34, 32'h1234_5678);
    bus_wr(8'h00, 32'h0);
    bus_wr(8'h20, 32'hFFFF_FFFF);
    bus_rd(8'h34, v); chk("R5", v, c);
    bus_rd(8'h20, v); chk("R10", v, 32'h0);
    bus_rd(8'h30, v); chk("R5", v, 32'h0);

    // constrained random
    for (int it = 0; it < 3000; it++) begin
      int unsigned op;
      tick = ($urandom % 4) != 0;
      op = $urandom % 8;
      case (op)
        0, 1, 2: bus_rd(pick_addr($urandom % 15), v);
        3: bus_wr(8'(8 + 4 * ($urandom % NCH)), m_cnt + ($urandom % 24));
        4: bus_wr(8'h24, $urandom);
        5: bus_wr(8'h2C, $urandom);
        6: bus_wr(8'h30, $urandom);
        default: bus_wr(pick_addr($urandom % 15), $urandom);
      endcase
      if ($urandom % 3 == 0) @(negedge clk);
    end
    for (int k = 0; k < 15; k++) bus_rd(pick_addr(k), v);

    done = 1'b1;
    running = 1'b0;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule